// File: doc/BRIEF.md
# Two-Channel Pulse Width Modulator

This block generates two independent pulse-width-modulated outputs from one source clock. Software reaches it through a small word-addressed register port. One shared control word holds a field group for each channel, and each channel has its own word that sets its period and its duty. Each channel divides the source clock into ticks and runs an up-counter over ticks. The output is at its active level while the counter is below the duty count. The active level is chosen per channel.

New period and duty values are held in a staging register and reach the counter only at the end of the running period, so a waveform is never cut short. A per-channel ready flag in the control word shows whether a staged value is still waiting. A per-channel bypass bit routes the raw source clock straight to the pin. That bypass overrides every other setting of the channel.

Top module: `dual_pwm`

## Requirements
- R1: After reset, the control word reads 0x3000_0000, which means all fields are zero and both ready flags are set. Both period words read zero, and both outputs sit high, which is the inactive level for a polarity bit of 0.
- R2: Word 0 is the control word. Word 1+n is the period word of channel n. The field group of channel n starts at bit 15·n and holds these fields:
  - bits 3:0: divider select
  - bit 4: run enable
  - bit 5: polarity
  - bit 6: clock gate
  - bit 7: spare
  - bit 8: spare
  - bit 9: bypass

  The two spare bits are stored and read back but have no effect on the output. Control bits 10–14, 25–27 and 30–31 read 0.
- R3: Control bit 28+n is the ready flag of channel n. It is read-only, and writing to it has no effect.
- R4: A divider select s from 0 to 14 gives one tick every s+1 source clocks. s = 15 gives one tick every source clock.
- R5: With period-word bits 31:16 = P and bits 15:0 = D, where D ≤ P, one output period lasts (P+1)·(s-ratio) clocks and is active for D·ratio of them.
- R6: With the polarity bit at 1, the active level is high. With it at 0, the active level is low and the inactive level is high.
- R7: A channel runs only when its enable bit and its gate bit are both 1. Otherwise its output holds the inactive level and its counter clears, so the next start begins with the active portion of a period.
- R8: D = 0 gives a constant inactive level. D ≥ P+1 gives a constant active level.
- R9: A period-word write on a running channel takes effect only after the running period ends. Reading the period word returns the last value written.
- R10: A period-word write clears the channel's ready flag. On a running channel, the flag returns high at the next period end. On a stopped channel, it returns high one clock later. A write that lands on the same clock edge as a period end stays pending until the following period end.
- R11: With the bypass bit set, the output follows the source clock, whatever the enable, gate and polarity bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word index: 0 control, 1+n channel n |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word, combinational |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
The hazard is a software write to a period word that lands on the same clock edge as the channel's own period end. The bench starts a channel at a known edge with a divide ratio of one, counts edges, and times its write to land exactly on the fifth edge, which is the end of a 5-clock period. It then judges the outcome at the pin and at the flag. The period that follows must still carry the old duty, the ready flag must stay low throughout that period, and only the period after it may show the new duty, with the flag high again.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  localparam int CH_STRIDE = 15;
  localparam int RDY_BASE  = 28;
  localparam int PSEL_W    = 4;
  localparam int CFG_W     = 10;
  localparam int DATA_W    = 32;

  // full stored field group of one channel (bit 0 = LSB of psel)
  typedef struct packed {
    logic              byp;
    logic              spare_b;
    logic              spare_a;
    logic              gate;
    logic              act;
    logic              en;
    logic [PSEL_W-1:0] psel;
  } ctrl_fld_t;

  // fields that drive a channel datapath
  typedef struct packed {
    logic              byp;
    logic              gate;
    logic              act;
    logic              en;
    logic [PSEL_W-1:0] psel;
  } run_cfg_t;

endpackage

// File: rtl/dpwm_presc.sv
module dpwm_presc
  import dpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);

  logic [PSEL_W-1:0] pre_q;
  logic [PSEL_W-1:0] pre_d;
  logic [PSEL_W-1:0] lim;
  logic              pre_en;

  // all-ones select means undivided
  assign lim    = (psel_i == {PSEL_W{1'b1}}) ? '0 : psel_i;
  // >= tolerates a select lowered below the running count
  assign tick_o = run_i & (pre_q >= lim);
  assign pre_en = 1'b1;

  always_comb begin
    pre_d = pre_q;
    if (!run_i)      pre_d = '0;
    else if (tick_o) pre_d = '0;
    else             pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  run_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] shd_prd_i,
  input  logic [CNT_W-1:0] shd_duty_i,
  input  logic             prd_wr_i,
  output logic             rdy_o,
  output logic             run_o,
  output logic             tick_o,
  output logic             pwm_o
);

  logic             run;
  logic             tick;
  logic             boundary;
  logic             load;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] prd_q, duty_q;
  logic             pend_q, pend_d;
  logic             wave;

  assign run = cfg_i.en & cfg_i.gate & ~cfg_i.byp;

  dpwm_presc u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .psel_i (cfg_i.psel),
    .tick_o (tick)
  );

  assign boundary = tick & (cnt_q == prd_q);
  assign load     = ~run | boundary;
  assign cnt_en   = ~run | tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)          cnt_d = '0;
    else if (boundary) cnt_d = '0;
    else if (tick)     cnt_d = cnt_q + 1'b1;
  end

  // a write in the same cycle as a load stays pending
  always_comb begin
    pend_d = prd_wr_i | (pend_q & ~load);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q  <= '0;
      duty_q <= '0;
    end else if (load) begin
      prd_q  <= shd_prd_i;
      duty_q <= shd_duty_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign wave   = ~cfg_i.act ^ (run & (cnt_q < duty_q));
  assign pwm_o  = cfg_i.byp ? clk : wave;
  assign rdy_o  = ~pend_q;
  assign run_o  = run;
  assign tick_o = tick;

endmodule

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  input  logic [NUM_CH-1:0]            rdy_i,
  output run_cfg_t [NUM_CH-1:0]        cfg_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] prd_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] duty_o,
  output logic [NUM_CH-1:0]            prd_wr_o
);

  localparam int PRD_LSB = DATA_W / 2;

  ctrl_fld_t [NUM_CH-1:0]        fld_q, fld_d;
  logic [NUM_CH-1:0][CNT_W-1:0]  prd_q, prd_d, duty_q, duty_d;
  logic                          ctl_wr;

  assign ctl_wr = wr_en & (addr == '0);

  always_comb begin
    fld_d    = fld_q;
    prd_d    = prd_q;
    duty_d   = duty_q;
    prd_wr_o = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      fld_d[ch] = ctrl_fld_t'(wdata[ch*CH_STRIDE +: CFG_W]);
      if (wr_en && (addr == ADDR_W'(ch + 1))) begin
        prd_wr_o[ch] = 1'b1;
        prd_d[ch]    = wdata[PRD_LSB +: CNT_W];
        duty_d[ch]   = wdata[0 +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fld_q <= '0;
    else if (ctl_wr) fld_q <= fld_d;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_prd
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prd_q[g]  <= '0;
          duty_q[g] <= '0;
        end else if (prd_wr_o[g]) begin
          prd_q[g]  <= prd_d[g];
          duty_q[g] <= duty_d[g];
        end
      end

      assign cfg_o[g].byp  = fld_q[g].byp;
      assign cfg_o[g].gate = fld_q[g].gate;
      assign cfg_o[g].act  = fld_q[g].act;
      assign cfg_o[g].en   = fld_q[g].en;
      assign cfg_o[g].psel = fld_q[g].psel;
    end
  endgenerate

  assign prd_o  = prd_q;
  assign duty_o = duty_q;

  always_comb begin
    rdata = '0;
    if (addr == '0) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        rdata[ch*CH_STRIDE +: CFG_W] = fld_q[ch];
        rdata[RDY_BASE + ch]         = rdy_i[ch];
      end
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (addr == ADDR_W'(ch + 1)) begin
          rdata[PRD_LSB +: CNT_W] = prd_q[ch];
          rdata[0 +: CNT_W]       = duty_q[ch];
        end
      end
    end
  end

endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  run_cfg_t [NUM_CH-1:0]        ch_cfg;
  logic [NUM_CH-1:0][CNT_W-1:0] shd_prd;
  logic [NUM_CH-1:0][CNT_W-1:0] shd_duty;
  logic [NUM_CH-1:0]            prd_wr;
  logic [NUM_CH-1:0]            ch_rdy;
  logic [NUM_CH-1:0]            ch_run;
  logic [NUM_CH-1:0]            ch_tick;

  dpwm_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .rdy_i    (ch_rdy),
    .cfg_o    (ch_cfg),
    .prd_o    (shd_prd),
    .duty_o   (shd_duty),
    .prd_wr_o (prd_wr)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      dpwm_chan #(
        .CNT_W (CNT_W)
      ) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (ch_cfg[g]),
        .shd_prd_i  (shd_prd[g]),
        .shd_duty_i (shd_duty[g]),
        .prd_wr_i   (prd_wr[g]),
        .rdy_o      (ch_rdy[g]),
        .run_o      (ch_run[g]),
        .tick_o     (ch_tick[g]),
        .pwm_o      (pwm_out[g])
      );
    end
  endgenerate

endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input run_cfg_t [NUM_CH-1:0] cfg,
  input logic [NUM_CH-1:0]     rdy,
  input logic [NUM_CH-1:0]     run,
  input logic [NUM_CH-1:0]     tick,
  input logic [NUM_CH-1:0]     pwm_out
);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      // R10
      ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(g + 1)) |=> !rdy[g]);

      // R10
      idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[g] && !(wr_en && addr == ADDR_W'(g + 1))) |=> rdy[g]);

      // R9
      ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy[g]) |-> $past(!run[g] || tick[g]));

      // R7
      idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[g].byp && !(cfg[g].en && cfg[g].gate)) |-> (pwm_out[g] == !cfg[g].act));

      // R11
      bypass_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[g].byp |-> !run[g]);

      // R4
      full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run[g] && cfg[g].psel == 4'hF) |-> tick[g]);
    end
  endgenerate

endmodule

bind dual_pwm dpwm_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .cfg     (ch_cfg),
  .rdy     (ch_rdy),
  .run     (ch_run),
  .tick    (ch_tick),
  .pwm_out (pwm_out)
);

// File: tb/test_dual_pwm.sv
module test_dual_pwm;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  pwm_out;

  int checks;
  int fails;
  bit done;

  dual_pwm i_dual_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pwm_out (pwm_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // field group of one channel
  function automatic logic [31:0] cw(input int ch, input logic [3:0] psel, input logic en,
                                     input logic act, input logic gate, input logic byp);
    logic [31:0] v;
    v = {22'd0, byp, 1'b0, 1'b0, gate, act, en, psel};
    return v << (15 * ch);
  endfunction

  // call at a falling edge; lands on the next rising edge, returns at the falling edge after it
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic count_hi(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      hi += int'(pwm_out[ch]);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    chk("R1 outputs", {30'd0, pwm_out}, 32'h3);
    rd(2'd0, d); chk("R1 ctrl", d, 32'h3000_0000);
    rd(2'd1, d); chk("R1 ch0 word", d, 32'h0);
    rd(2'd2, d); chk("R1 ch1 word", d, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d, f;
    @(negedge clk);
    f = cw(0, 4'h5, 1'b0, 1'b1, 1'b0, 1'b0) | (32'h3 << 7) | cw(1, 4'hA, 1'b0, 1'b0, 1'b1, 1'b0);
    wr(2'd0, f | 32'hFE00_7C00);
    rd(2'd0, d); chk("R2 R3 ctrl readback", d, f | 32'h3000_0000);
    chk("R7 stopped levels", {30'd0, pwm_out}, 32'h2);
    wr(2'd1, 32'h1234_0056);
    @(negedge clk);
    rd(2'd1, d); chk("R9 period word readback", d, 32'h1234_0056);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_basic();
    int hi;
    @(negedge clk);
    wr(2'd1, (32'd9 << 16) | 32'd3);
    wr(2'd0, cw(0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0) | (32'h1 << 8));
    count_hi(0, 25, hi);
    count_hi(0, 40, hi); chk("R5 duty 3 of 10", hi, 12);
    wr(2'd0, cw(0, 4'h1, 1'b1, 1'b1, 1'b1, 1'b0));
    count_hi(0, 40, hi);
    count_hi(0, 60, hi); chk("R4 divide by 2", hi, 18);
    wr(2'd0, cw(0, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0));
    count_hi(0, 25, hi);
    count_hi(0, 40, hi); chk("R6 inverted level", hi, 28);
  endtask

  task automatic t_ch1();
    int hi;
    @(negedge clk);
    wr(2'd2, (32'd4 << 16) | 32'd2);
    wr(2'd0, cw(0, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0) | cw(1, 4'h2, 1'b1, 1'b1, 1'b1, 1'b0));
    count_hi(1, 30, hi);
    count_hi(1, 45, hi); chk("R4 R5 ch1 divide by 3", hi, 18);
    count_hi(0, 40, hi); chk("R5 ch0 alongside ch1", hi, 28);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_gate();
    int hi;
    logic [9:0] pat;
    @(negedge clk);
    wr(2'd0, cw(0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0));
    count_hi(0, 30, hi); chk("R7 gate off", hi, 0);
    wr(2'd0, cw(0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0));
    count_hi(0, 30, hi); chk("R7 enable off", hi, 30);
    wr(2'd0, 32'h0);
    wr(2'd0, cw(0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0));
    pat[9] = pwm_out[0];
    for (int i = 8; i >= 0; i--) begin
      @(negedge clk);
      pat[i] = pwm_out[0];
    end
    chk("R7 restart phase", {22'd0, pat}, 32'h380);
  endtask

  task automatic t_duty();
    int hi;
    @(negedge clk);
    wr(2'd1, (32'd9 << 16) | 32'd0);
    count_hi(0, 25, hi);
    count_hi(0, 30, hi); chk("R8 duty zero", hi, 0);
    wr(2'd1, (32'd9 << 16) | 32'hFFFF);
    count_hi(0, 25, hi);
    count_hi(0, 30, hi); chk("R8 duty max", hi, 30);
    wr(2'd1, (32'd9 << 16) | 32'd10);
    count_hi(0, 25, hi);
    count_hi(0, 30, hi); chk("R8 duty equals period", hi, 30);
    wr(2'd1, (32'd9 << 16) | 32'd9);
    count_hi(0, 25, hi);
    count_hi(0, 30, hi); chk("R5 duty 9 of 10", hi, 27);
  endtask

  task automatic t_update();
    logic [31:0] d;
    int h0, h1, h2;
    @(negedge clk);
    wr(2'd0, 32'h0);
    wr(2'd1, (32'd9 << 16) | 32'd3);
    wr(2'd0, cw(0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0));
    h0 = int'(pwm_out[0]);
    wr(2'd1, (32'd9 << 16) | 32'd7);
    h0 += int'(pwm_out[0]);
    rd(2'd0, d); chk("R10 ready low after write", {31'd0, d[28]}, 32'h0);
    count_hi(0, 8, h1);
    h0 += h1;
    chk("R9 old duty kept to period end", h0, 3);
    @(negedge clk);
    rd(2'd0, d); chk("R10 ready back at period end", {31'd0, d[28]}, 32'h1);
    h2 = int'(pwm_out[0]);
    count_hi(0, 9, h1);
    chk("R9 new duty next period", h2 + h1, 7);
  endtask

  task automatic t_coincide();
    logic [31:0] d;
    int h, hi;
    @(negedge clk);
    wr(2'd0, 32'h0);
    wr(2'd1, (32'd4 << 16) | 32'd1);
    wr(2'd0, cw(0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (4) @(negedge clk);
    wr(2'd1, (32'd4 << 16) | 32'd4);
    h = int'(pwm_out[0]);
    rd(2'd0, d); chk("R10 coincident write pending", {31'd0, d[28]}, 32'h0);
    count_hi(0, 4, hi);
    chk("R10 coincident write not taken", h + hi, 1);
    rd(2'd0, d); chk("R10 still pending late in period", {31'd0, d[28]}, 32'h0);
    @(negedge clk);
    rd(2'd0, d); chk("R10 ready after following end", {31'd0, d[28]}, 32'h1);
    h = int'(pwm_out[0]);
    count_hi(0, 4, hi);
    chk("R10 coincident value applied", h + hi, 4);
  endtask

  task automatic t_idle_rdy();
    logic [31:0] d;
    @(negedge clk);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0003_0001);
    rd(2'd0, d); chk("R10 stopped ch1 ready low", {31'd0, d[29]}, 32'h0);
    @(negedge clk);
    rd(2'd0, d); chk("R10 stopped ch1 ready high", {31'd0, d[29]}, 32'h1);
  endtask

  task automatic t_bypass();
    logic [31:0] s;
    @(negedge clk);
    wr(2'd0, cw(0, 4'h3, 1'b0, 1'b0, 1'b0, 1'b1));
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      s = {30'd0, pwm_out}; chk("R11 bypass high phase", s, 32'h3);
      @(negedge clk); #2;
      s = {30'd0, pwm_out}; chk("R11 bypass low phase", s, 32'h2);
    end
    wr(2'd0, cw(0, 4'h3, 1'b0, 1'b1, 1'b0, 1'b0));
    chk("R11 bypass released", {30'd0, pwm_out}, 32'h2);
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    addr   = '0;
    wdata  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_basic();
    t_ch1();
    t_gate();
    t_duty();
    t_update();
    t_coincide();
    t_idle_rdy();
    t_bypass();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule